// File: doc/BRIEF.md
# Packed Bytecode Instruction Decoder

This block decodes one instruction of a byte-oriented bytecode from a 13-byte window. Byte 0 of the window (`in_bytes[7:0]`) holds the opcode, and the operands follow it with no padding. The opcode picks one of eight operand layouts. The block reports the following:

- the layout code;
- the total instruction length in bytes;
- up to four register-index bytes;
- a 64-bit immediate and a 16-bit immediate, both assembled little-endian;
- a trap flag for opcodes that are not defined.

The decode is combinational. Its result is captured by one register stage whenever `in_valid` is high. The surrounding fetch logic shifts its byte window by `out_len` to reach the next instruction. Fetch, execution and program-counter updates are left to that logic.

Top module: `insn_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first output after release, `out_valid` is 0 and every other output is 0.
- R2: `out_valid` equals `in_valid` from the previous clock. When `in_valid` is low, all decoded outputs keep their previous values.
- R3: Layout codes on `out_fmt`:
  - 0 (no operands): opcodes 0 and 39, and every undefined opcode.
  - 1 (two regs): opcodes 13–14, 25–26 and 45–47.
  - 2 (three regs): opcodes 1–11, 31 and 40–42.
  - 3 (four regs): opcodes 12, 43 and 44.
  - 4 (one reg + 64-bit immediate): opcodes 27 and 32.
  - 5 (two regs + 64-bit immediate): opcodes 15–24, 30, 33–38 and 48–49.
  - 6 (two regs + 64-bit + 16-bit immediates): opcodes 28–29.
  - 7 (64-bit immediate only) is reserved and never produced.
- R4: `out_len` is 1 plus the operand bytes. By layout code 0..7 the lengths are 1, 3, 4, 5, 10, 11, 13 and 9.
- R5: Register index n (`out_ra`=0 … `out_rd`=3) is window byte n+1 when the layout carries more than n registers, and 0 otherwise.
- R6: `out_imm64` is 8 window bytes taken little-endian (lowest byte is least significant). It starts at byte 2 for layout 4, at byte 3 for layouts 5 and 6, and at byte 1 for layout 7. For every other layout it is 0.
- R7: `out_imm16` is window bytes 11 (low) and 12 (high) for layout 6, and 0 otherwise.
- R8: For an opcode above 49, `out_trap` is 1 and `out_opcode` shows the offending opcode. In the same case `out_fmt` is 0, `out_len` is 1, and all register and immediate outputs are 0. For opcodes 0–49, `out_trap` is 0.
- R9: Window bytes at or beyond the decoded length have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window holds an instruction to decode |
| in_bytes | input | 8*WIN_BYTES | Instruction window, byte k at bits 8k+7:8k |
| out_valid | output | 1 | Decoded result valid |
| out_opcode | output | 8 | Opcode byte |
| out_fmt | output | 3 | Operand layout code |
| out_len | output | 4 | Instruction length in bytes |
| out_ra | output | 8 | Register index 0 |
| out_rb | output | 8 | Register index 1 |
| out_rc | output | 8 | Register index 2 |
| out_rd | output | 8 | Register index 3 |
| out_imm64 | output | 64 | 64-bit immediate |
| out_imm16 | output | 16 | 16-bit immediate |
| out_trap | output | 1 | Undefined opcode |

## Verification
The bench walks every edge of each opcode range: 11/12, 14/15, 24/25, 27/28, 29/30/31/32, 38/39/40, 42/43, 44/45 and 49/50. A range table that is off by one misclassifies one of these and gets the length wrong. Each vector fills the bytes past the instruction end with nonzero data. An extractor that uses the wrong byte offset, reverses the immediate byte order, or leaks trailing bytes into unused fields then shows a mismatch. Opcode 50 and opcode 255 check that the trap fires with zeroed fields. Idle cycles with a changing window check that the output stage does not pick up data without `in_valid`.

// File: rtl/insn_decoder.sv
module insn_decoder #(
  parameter int WIN_BYTES = 13,
  parameter int MAX_OP    = 49
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [8*WIN_BYTES-1:0] in_bytes,
  output logic                   out_valid,
  output logic [7:0]             out_opcode,
  output logic [2:0]             out_fmt,
  output logic [3:0]             out_len,
  output logic [7:0]             out_ra,
  output logic [7:0]             out_rb,
  output logic [7:0]             out_rc,
  output logic [7:0]             out_rd,
  output logic [63:0]            out_imm64,
  output logic [15:0]            out_imm16,
  output logic                   out_trap
);

  localparam logic [2:0] F_NONE = 3'd0, F_R2 = 3'd1, F_R3 = 3'd2, F_R4 = 3'd3,
                         F_RD = 3'd4, F_RRD = 3'd5, F_RRDH = 3'd6, F_D = 3'd7;

  logic [7:0] bt [WIN_BYTES];
  for (genvar g = 0; g < WIN_BYTES; g++) begin : g_split
    assign bt[g] = in_bytes[8*g +: 8];
  end

  wire [7:0] op  = bt[0];
  wire       bad = (int'(op) > MAX_OP);

  logic [2:0]  fmt_c;
  logic [3:0]  len_c, ioff_c;
  logic [2:0]  nreg_c;
  logic [7:0]  reg_c [4];
  logic [63:0] imm_c;
  logic [15:0] imh_c;

  always_comb begin
    fmt_c = F_NONE;
    if (!bad) begin
      case (op) inside
        [8'd1:8'd11], 8'd31, [8'd40:8'd42]:                    fmt_c = F_R3;
        8'd12, 8'd43, 8'd44:                                   fmt_c = F_R4;
        [8'd13:8'd14], [8'd25:8'd26], [8'd45:8'd47]:           fmt_c = F_R2;
        [8'd15:8'd24], 8'd30, [8'd33:8'd38], [8'd48:8'd49]:    fmt_c = F_RRD;
        8'd27, 8'd32:                                          fmt_c = F_RD;
        [8'd28:8'd29]:                                         fmt_c = F_RRDH;
        default:                                               fmt_c = F_NONE;
      endcase
    end
  end

  always_comb begin
    case (fmt_c)
      F_R2:    begin len_c = 4'd3;  nreg_c = 3'd2; ioff_c = 4'd0; end
      F_R3:    begin len_c = 4'd4;  nreg_c = 3'd3; ioff_c = 4'd0; end
      F_R4:    begin len_c = 4'd5;  nreg_c = 3'd4; ioff_c = 4'd0; end
      F_RD:    begin len_c = 4'd10; nreg_c = 3'd1; ioff_c = 4'd2; end
      F_RRD:   begin len_c = 4'd11; nreg_c = 3'd2; ioff_c = 4'd3; end
      F_RRDH:  begin len_c = 4'd13; nreg_c = 3'd2; ioff_c = 4'd3; end
      F_D:     begin len_c = 4'd9;  nreg_c = 3'd0; ioff_c = 4'd1; end
      default: begin len_c = 4'd1;  nreg_c = 3'd0; ioff_c = 4'd0; end
    endcase
  end

  always_comb begin
    for (int i = 0; i < 4; i++)
      reg_c[i] = (3'(i) < nreg_c) ? bt[4'(i + 1)] : 8'h00;
    imm_c = '0;
    if (ioff_c != 4'd0)
      for (int k = 0; k < 8; k++)
        imm_c[8*k +: 8] = bt[ioff_c + 4'(k)];
  end

  assign imh_c = (fmt_c == F_RRDH) ? {bt[12], bt[11]} : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_opcode <= '0;
      out_fmt    <= '0;
      out_len    <= '0;
      out_ra     <= '0;
      out_rb     <= '0;
      out_rc     <= '0;
      out_rd     <= '0;
      out_imm64  <= '0;
      out_imm16  <= '0;
      out_trap   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_opcode <= op;
        out_fmt    <= fmt_c;
        out_len    <= len_c;
        out_ra     <= reg_c[0];
        out_rb     <= reg_c[1];
        out_rc     <= reg_c[2];
        out_rd     <= reg_c[3];
        out_imm64  <= imm_c;
        out_imm16  <= imh_c;
        out_trap   <= bad;
      end
    end
  end

endmodule

// File: rtl/insn_decoder_chk.sv
module insn_decoder_chk #(
  parameter int MAX_OP = 49
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        out_valid,
  input logic [7:0]  out_opcode,
  input logic [2:0]  out_fmt,
  input logic [3:0]  out_len,
  input logic [7:0]  out_ra,
  input logic [7:0]  out_rb,
  input logic [7:0]  out_rc,
  input logic [7:0]  out_rd,
  input logic [63:0] out_imm64,
  input logic [15:0] out_imm16,
  input logic        out_trap
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_opcode) && $stable(out_imm64) && $stable(out_len)));

  // R8
  trap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_trap == (int'(out_opcode) > MAX_OP)));

  // R8
  trap_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_trap) |-> (out_fmt == 3'd0 && out_len == 4'd1 && out_imm64 == 64'd0));

  // R4
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len >= 4'd1 && out_len <= 4'd13));

  // R7
  imm16_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt != 3'd6) |-> (out_imm16 == 16'h0000));

  // R5
  regs_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt == 3'd0) |-> ({out_ra, out_rb, out_rc, out_rd} == 32'd0));

  // R6
  imm64_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt <= 3'd3) |-> (out_imm64 == 64'd0));

endmodule

bind insn_decoder insn_decoder_chk #(.MAX_OP(MAX_OP)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_opcode(out_opcode), .out_fmt(out_fmt), .out_len(out_len),
  .out_ra(out_ra), .out_rb(out_rb), .out_rc(out_rc), .out_rd(out_rd),
  .out_imm64(out_imm64), .out_imm16(out_imm16), .out_trap(out_trap)
);

// File: tb/insn_decoder_tb.sv
`timescale 1ns/1ps
module insn_decoder_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [103:0] in_bytes = '0;
  logic         out_valid, out_trap;
  logic [7:0]   out_opcode, out_ra, out_rb, out_rc, out_rd;
  logic [2:0]   out_fmt;
  logic [3:0]   out_len;
  logic [63:0]  out_imm64;
  logic [15:0]  out_imm16;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  insn_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
    .out_valid(out_valid), .out_opcode(out_opcode), .out_fmt(out_fmt),
    .out_len(out_len), .out_ra(out_ra), .out_rb(out_rb), .out_rc(out_rc),
    .out_rd(out_rd), .out_imm64(out_imm64), .out_imm16(out_imm16),
    .out_trap(out_trap)
  );

  // {opcode, fmt, len, nregs, imm64 start byte (0 = none), pad}
  localparam int NV = 29;
  localparam logic [31:0] VEC [NV] = '{
    32'h00_0_1_0_0_00, 32'h27_0_1_0_0_00, 32'h01_2_4_3_0_00, 32'h0B_2_4_3_0_00,
    32'h1F_2_4_3_0_00, 32'h28_2_4_3_0_00, 32'h2A_2_4_3_0_00, 32'h0C_3_5_4_0_00,
    32'h2B_3_5_4_0_00, 32'h2C_3_5_4_0_00, 32'h0D_1_3_2_0_00, 32'h0E_1_3_2_0_00,
    32'h19_1_3_2_0_00, 32'h1A_1_3_2_0_00, 32'h2D_1_3_2_0_00, 32'h2F_1_3_2_0_00,
    32'h0F_5_B_2_3_00, 32'h18_5_B_2_3_00, 32'h1E_5_B_2_3_00, 32'h21_5_B_2_3_00,
    32'h26_5_B_2_3_00, 32'h30_5_B_2_3_00, 32'h31_5_B_2_3_00, 32'h1B_4_A_1_2_00,
    32'h20_4_A_1_2_00, 32'h1C_6_D_2_3_00, 32'h1D_6_D_2_3_00, 32'h32_0_1_0_0_00,
    32'hFF_0_1_0_0_00
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [103:0] fill(input logic [7:0] op, input int seed);
    logic [103:0] w;
    w[7:0] = op;
    for (int i = 1; i < 13; i++) w[8*i +: 8] = 8'(i * 17 + seed * 29 + 3);
    return w;
  endfunction

  task automatic check_entry(input logic [31:0] e, input logic [103:0] w, input string tag);
    logic [7:0] op;
    logic [3:0] fmt, len, nr, off;
    logic [63:0] imm;
    logic [7:0] rg [4];
    op = e[31:24]; fmt = e[23:20]; len = e[19:16]; nr = e[15:12]; off = e[11:8];
    for (int i = 0; i < 4; i++) rg[i] = (i < int'(nr)) ? w[8*(i+1) +: 8] : 8'h00;
    imm = '0;
    if (off != 0) for (int k = 0; k < 8; k++) imm[8*k +: 8] = w[8*(int'(off)+k) +: 8];
    check({tag, " R2 valid"}, 64'(out_valid), 64'd1);
    check({tag, " R8 opcode"}, 64'(out_opcode), 64'(op));
    check({tag, " R3 fmt"}, 64'(out_fmt), 64'(fmt[2:0]));
    check({tag, " R4 len"}, 64'(out_len), 64'(len));
    check({tag, " R5 ra"}, 64'(out_ra), 64'(rg[0]));
    check({tag, " R5 rb"}, 64'(out_rb), 64'(rg[1]));
    check({tag, " R5 rc"}, 64'(out_rc), 64'(rg[2]));
    check({tag, " R5 rd"}, 64'(out_rd), 64'(rg[3]));
    check({tag, " R6 imm64"}, out_imm64, imm);
    check({tag, " R7 imm16"}, 64'(out_imm16), (fmt == 4'd6) ? 64'({w[103:96], w[95:88]}) : 64'd0);
    check({tag, " R8 trap"}, 64'(out_trap), 64'(op > 8'd49));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [103:0] w;
    logic [63:0] keep;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", 64'(out_valid), 64'd0);
    check("R1 fields", {out_opcode, out_ra, out_rb, out_rc, out_rd, 24'd0}, 64'd0);
    check("R1 imm", out_imm64 | 64'(out_imm16) | 64'({out_trap, out_fmt, out_len}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 64'(out_valid), 64'd0);

    for (int v = 0; v < NV; v++) begin
      w = fill(VEC[v][31:24], v);
      in_bytes = w; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_entry(VEC[v], w, $sformatf("vec%0d", v));
    end

    // R2: back-to-back valids, then hold while idle with changing window
    w = fill(8'd28, 100); in_bytes = w; in_valid = 1'b1;
    @(negedge clk);
    check_entry(VEC[25], w, "b2b0");
    w = fill(8'd27, 101); in_bytes = w;
    @(negedge clk);
    check_entry(VEC[23], w, "b2b1");
    in_valid = 1'b0; keep = out_imm64;
    in_bytes = fill(8'd3, 55);
    @(negedge clk);
    in_bytes = fill(8'd60, 56);
    @(negedge clk);
    check("R2 idle valid", 64'(out_valid), 64'd0);
    check("R2 idle opcode hold", 64'(out_opcode), 64'd27);
    check("R2 idle imm hold", out_imm64, keep);

    // R9: trailing bytes beyond length do not matter
    in_bytes = {8'hAA, 8'hBB, 8'hCC, 16'h0, 64'h0, 8'd27} | 104'h0;
    in_bytes[7:0] = 8'd27; in_bytes[15:8] = 8'h11;
    for (int k = 0; k < 8; k++) in_bytes[16 + 8*k +: 8] = 8'(k + 1);
    in_valid = 1'b1;
    @(negedge clk);
    keep = out_imm64;
    in_bytes[103:80] = 24'h5A5A5A;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 imm64 unchanged", out_imm64, keep);
    check("R9 imm64 value", out_imm64, 64'h0807060504030201);
    check("R9 rb zero", 64'(out_rb), 64'd0);
    check("R9 imm16 zero", 64'(out_imm16), 64'd0);

    in_bytes = {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 8'd0};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 nop regs", 64'({out_ra, out_rb, out_rc, out_rd}), 64'd0);
    check("R9 nop imm", out_imm64, 64'd0);
    check("R9 nop len", 64'(out_len), 64'd1);

    // R1: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset", 64'({out_valid, out_len, out_fmt}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule